// File: doc/BRIEF.md
# Switchable 12/24-Hour BCD Hour Counter

This block keeps the hour of a digital clock as two BCD digits. A units digit counts with a modulus of 10, 4 or 2. Its rollover advances a modulo-3 tens digit. The active modulus is chosen on every increment from the current tens value and a format-select input. In 24-hour format the count runs from 00 to 23. In 12-hour format it runs from 00 to 11.

The block advances by one hour on each cycle in which its count-enable input is high. That input is normally the carry of the minutes stage. When the count wraps back to 00, the block raises a one-cycle carry so that a day counter can be chained after it. A registered indicator shows which format is currently in force. Reset is synchronous and active high.

Top module: `hour_bcd_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 00, `day_carry` becomes 0 and `fmt_is_12` becomes 0 (24-hour format).
- R2: At an edge where `inc` is low, the count keeps its value and `day_carry` is 0.
- R3: With `fmt12` = 0, successive increments give 00, 01 … 09, 10 … 19, 20, 21, 22, 23, then 00. The units digit wraps after 9 while the tens digit is 0 or 1, and after 3 while the tens digit is 2.
- R4: With `fmt12` = 1, successive increments give 00 … 09, 10, 11, then 00. The units digit wraps after 1 while the tens digit is 1, and the tens digit never reaches 2.
- R5: `day_carry` is high for exactly one cycle: the cycle after an edge at which the count wrapped to 00. In that cycle the outputs read 00.
- R6: `fmt_is_12` equals the value `fmt12` had at the previous clock edge (1 = 12-hour format, 0 = 24-hour format).
- R7: If the count lies above 11 while `fmt12` = 1 (for example 15 or 20 left over from 24-hour counting), the next increment gives 00 and raises `day_carry`.
- R8: `hour_tens` always holds a value from 0 to 2 and `hour_units` a value from 0 to 9 (4-bit BCD).
- R9: Changing `fmt12` from 1 to 0 keeps the current count. Counting then continues in 24-hour order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc | input | 1 | Advance one hour at this edge |
| fmt12 | input | 1 | Format select: 1 = 12-hour, 0 = 24-hour |
| hour_tens | output | 4 | BCD tens digit of the hour |
| hour_units | output | 4 | BCD units digit of the hour |
| day_carry | output | 1 | One-cycle pulse after a wrap to 00 |
| fmt_is_12 | output | 1 | Registered copy of the active format |

## Verification
The assertions are checked on every cycle. They cover the digit ranges, holding the count while idle, the one-cycle carry that appears only with a 00 reading, the one-cycle delay of the format indicator, and the wraps from 23 and from 11. Other behaviour can only be shown by the bench's scenarios. This covers the full ordering of the hour sequence in each format, the modulus change between the tens values, and forcing an out-of-range count to 00 after a format switch. It also covers keeping the count when the format switches back to 24-hour.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    localparam int DIGIT_W    = 4;
    localparam int UNITS_TOP  = 9;   // last units value in a full decade
    localparam int TENS_TOP24 = 2;   // last tens value, 24-hour format
    localparam int TENS_TOP12 = 1;   // last tens value, 12-hour format
    localparam int UNITS_END24 = 3;  // last units value when tens is at top, 24h
    localparam int UNITS_END12 = 1;  // last units value when tens is at top, 12h

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef enum logic {
        FMT_24 = 1'b0,
        FMT_12 = 1'b1
    } fmt_e;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } hour_t;

    function automatic bcd_t tens_top(fmt_e f);
        return (f == FMT_12) ? bcd_t'(TENS_TOP12) : bcd_t'(TENS_TOP24);
    endfunction

    // Last units value before the units digit rolls over
    function automatic bcd_t units_top(bcd_t tens, fmt_e f);
        bcd_t r;
        if (tens >= tens_top(f))
            r = (f == FMT_12) ? bcd_t'(UNITS_END12) : bcd_t'(UNITS_END24);
        else
            r = bcd_t'(UNITS_TOP);
        return r;
    endfunction

    // Count lies beyond the final hour of the selected format
    function automatic logic beyond_end(hour_t h, fmt_e f);
        logic r;
        if (h.tens > tens_top(f))
            r = 1'b1;
        else if (h.tens == tens_top(f) && h.units > units_top(h.tens, f))
            r = 1'b1;
        else
            r = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/hrs_units_digit.sv
module hrs_units_digit
    import hrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic clear,
    input  bcd_t last,
    output bcd_t value,
    output logic roll
);

    assign roll = inc && (value >= last);

    always_ff @(posedge clk) begin
        if (rst || clear)
            value <= '0;
        else if (roll)
            value <= '0;
        else if (inc)
            value <= value + bcd_t'(1);
    end

endmodule

// File: rtl/hrs_tens_digit.sv
module hrs_tens_digit
    import hrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic clear,
    output bcd_t value
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            value <= '0;
        else if (adv)
            value <= value + bcd_t'(1);
    end

endmodule

// File: rtl/hour_bcd_counter.sv
module hour_bcd_counter
    import hrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic       fmt12,
    output logic [3:0] hour_tens,
    output logic [3:0] hour_units,
    output logic       day_carry,
    output logic       fmt_is_12
);

    fmt_e  fmt;
    hour_t cur;
    bcd_t  u_last;
    logic  u_roll;
    logic  at_final;
    logic  wrap;

    assign fmt    = fmt_e'(fmt12);
    assign u_last = units_top(cur.tens, fmt);

    // Whole-count wrap: final hour reached, or count left out of range
    assign at_final = (cur.tens >= tens_top(fmt)) && (cur.units >= u_last);
    assign wrap     = inc && (at_final || beyond_end(cur, fmt));

    hrs_units_digit u_units (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc),
        .clear (wrap),
        .last  (u_last),
        .value (cur.units),
        .roll  (u_roll)
    );

    hrs_tens_digit u_tens (
        .clk   (clk),
        .rst   (rst),
        .adv   (u_roll),
        .clear (wrap),
        .value (cur.tens)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            day_carry <= 1'b0;
            fmt_is_12 <= 1'b0;
        end else begin
            day_carry <= wrap;
            fmt_is_12 <= fmt12;
        end
    end

    assign hour_tens  = cur.tens;
    assign hour_units = cur.units;

endmodule

// File: rtl/hour_bcd_counter_chk.sv
module hour_bcd_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       inc,
    input logic       fmt12,
    input logic [3:0] hour_tens,
    input logic [3:0] hour_units,
    input logic       day_carry,
    input logic       fmt_is_12
);

    // R8
    tens_range_chk: assert property (@(posedge clk) disable iff (rst)
        hour_tens <= 4'd2);

    // R8
    units_range_chk: assert property (@(posedge clk) disable iff (rst)
        hour_units <= 4'd9);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> ($stable(hour_tens) && $stable(hour_units) && !day_carry));

    // R5
    carry_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        day_carry |-> (hour_tens == 4'd0 && hour_units == 4'd0));

    // R5
    carry_single_chk: assert property (@(posedge clk) disable iff (rst)
        day_carry |=> !day_carry);

    // R6
    fmt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fmt_is_12 == $past(fmt12)));

    // R3
    wrap24_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !fmt12 && hour_tens == 4'd2 && hour_units == 4'd3) |=> day_carry);

    // R4
    wrap12_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && fmt12 && hour_tens == 4'd1 && hour_units == 4'd1) |=> day_carry);

endmodule

bind hour_bcd_counter hour_bcd_counter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .inc        (inc),
    .fmt12      (fmt12),
    .hour_tens  (hour_tens),
    .hour_units (hour_units),
    .day_carry  (day_carry),
    .fmt_is_12  (fmt_is_12)
);

// File: tb/sim_hour_bcd_counter.sv
module sim_hour_bcd_counter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc = 1'b0;
    logic       fmt12 = 1'b0;
    logic [3:0] hour_tens;
    logic [3:0] hour_units;
    logic       day_carry;
    logic       fmt_is_12;

    typedef struct {
        int    t;
        int    u;
        bit    c;
        bit    f;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    int   model_h = 0;
    bit   done = 1'b0;

    hour_bcd_counter u0 (
        .clk        (clk),
        .rst        (rst),
        .inc        (inc),
        .fmt12      (fmt12),
        .hour_tens  (hour_tens),
        .hour_units (hour_units),
        .day_carry  (day_carry),
        .fmt_is_12  (fmt_is_12)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: the hour is kept as a plain number, wrapping past the format's final hour
    task automatic drive(input bit r, input bit i, input bit f, input string tag);
        exp_t e;
        int   hmax;
        @(negedge clk);
        rst = r; inc = i; fmt12 = f;
        e.c = 1'b0;
        if (r) begin
            model_h = 0;
            e.f = 1'b0;
        end else begin
            e.f = f;
            if (i) begin
                hmax = f ? 11 : 23;
                if (model_h >= hmax) begin
                    model_h = 0;
                    e.c = 1'b1;
                end else begin
                    model_h++;
                end
            end
        end
        e.t = model_h / 10;
        e.u = model_h % 10;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run(input int n, input bit i, input bit f, input string tag);
        for (int k = 0; k < n; k++) drive(1'b0, i, f, tag);
    endtask

    // Monitor: compares just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (hour_tens != 4'(e.t) || hour_units != 4'(e.u) ||
                    day_carry != e.c || fmt_is_12 != e.f) begin
                    n_fail++;
                    $display("FAIL %s: got %0d%0d carry=%0b fmt=%0b, expected %0d%0d carry=%0b fmt=%0b",
                             e.tag, hour_tens, hour_units, day_carry, fmt_is_12,
                             e.t, e.u, e.c, e.f);
                end
            end
        end
    end

    initial begin
        drive(1'b1, 1'b1, 1'b1, "R1 reset");
        drive(1'b1, 1'b0, 1'b0, "R1 reset");
        run(3, 1'b0, 1'b0, "R2 idle");
        run(24, 1'b1, 1'b0, "R3 24h sequence / R5 wrap");
        run(2, 1'b0, 1'b0, "R5 carry drops / R2 idle");
        run(15, 1'b1, 1'b0, "R3 climb to 15");
        drive(1'b0, 1'b0, 1'b1, "R6 indicator to 12h");
        drive(1'b0, 1'b1, 1'b1, "R7 15 in 12h wraps");
        run(12, 1'b1, 1'b1, "R4 12h sequence");
        run(7, 1'b1, 1'b1, "R4 climb to 07");
        drive(1'b0, 1'b0, 1'b0, "R9 switch to 24h keeps count");
        run(13, 1'b1, 1'b0, "R9 continue to 20");
        drive(1'b0, 1'b1, 1'b1, "R7 20 in 12h wraps");
        drive(1'b0, 1'b0, 1'b1, "R5 single pulse");
        drive(1'b1, 1'b0, 1'b1, "R1 reset again");
        drive(1'b0, 1'b0, 1'b0, "R2 idle after reset");
        @(negedge clk);
        inc = 1'b0;
        while (q.size() > 0) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int w = 0; w < 5000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule